// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is the slave side of a 512-byte serial nonvolatile memory that sits on a four-wire SPI-style bus (select, clock, data in, data out) with an extra pause input. It oversamples all bus pins with the system clock. It takes in an 8-bit command, then an address of up to nine bits, and then streams bytes in or out. Bytes being written are collected in a small page buffer. Array writes and status writes then run as a self-timed cycle whose length is counted in system clocks.

A separate protection unit owns the write-enable latch and the block-protect settings. This block sends it one-clock pulses when a set-latch or clear-latch command is accepted, and a pulse with the data byte when a status write commits. It also sends a done pulse when a write cycle ends. A single grant input tells the block whether a write that is about to commit is allowed. The status byte shifted out by a status read comes in on a port.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `so_oe` and `busy` are low, and no command is accepted until a high-to-low transition is seen on `cs_n`. A command clocked while `cs_n` was already low at reset has no effect.
- R2: Commands are 8 bits, sent most significant bit first. 0x06 sets the latch, 0x04 clears the latch, 0x05 reads status and 0x01 writes status. A read is 0000_A011 and a write is 0000_A010, where bit 3 of the command byte is address bit 8. Unknown codes are ignored until the next select.
- R3: A read takes 8 more address bits and then shifts out the addressed byte. The address steps by one after every byte and wraps from 0x1FF to 0x000 for as long as `cs_n` stays low.
- R4: A status read shifts out `stat_in`. During a write cycle it shifts out 0xFF instead.
- R5: A write stores its data bytes in a 4-byte page. The low 2 address bits advance after each byte and wrap inside the page, so later bytes overwrite earlier ones. When the cycle starts, only the page slots that received data are written to the array.
- R6: An array write or status write commits only when `cs_n` rises after bit 0 of a complete data byte and `wr_grant` is high at that moment. A rise at any other bit position abandons the write: `busy` stays low and the array is unchanged.
- R7: `wel_set` or `wel_clr` pulses for one clock only when `cs_n` rises straight after the eighth bit of the matching command. Any extra clock before the rise cancels it.
- R8: A committed write holds `busy` high for exactly `WR_CYCLES` clocks. `wr_done` pulses in the last of those clocks. While `busy` is high, every command except the status read is ignored.
- R9: `hold_n` falling while SCK is high pauses the transfer. SO is released, and SCK and SI changes are ignored until `hold_n` rises while SCK is high. The transfer then continues from the same bit.
- R10: SI is captured on the falling edge of SCK and SO changes after the rising edge. `so_oe` is high only while selected, not paused and in an output phase. It drops when `cs_n` rises.
- R11: A committed status write pulses `sr_load` with the received byte on `sr_data` and starts a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for the SO pad driver |
| wr_grant | input | 1 | Protection unit permits the pending write |
| stat_in | input | 8 | Status byte shown by a status read |
| wel_set | output | 1 | Pulse: set-latch command accepted |
| wel_clr | output | 1 | Pulse: clear-latch command accepted |
| sr_load | output | 1 | Pulse: status write committed |
| sr_data | output | 8 | Status byte received by a status write |
| tgt_addr | output | 9 | Current command address, for protection lookup |
| busy | output | 1 | Self-timed write cycle in progress |
| wr_done | output | 1 | Pulse in the last clock of a write cycle |

## Verification
The bench builds the block with `WR_CYCLES` = 600 and the default 4-byte page. With a cycle that long, a full status read and a refused array read both fit inside one write cycle, which makes the 0xFF status value and the busy lockout observable. The 4-byte page lets a six-byte write show the in-page wrap, and a page at 0x1FC next to page 0x000 puts the end-of-array read wrap within a few bytes.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int ADDR_W = 9;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_MEM_MASK = 8'hF6;
  localparam logic [7:0] OP_MEM_BASE = 8'h02;

  typedef enum logic [3:0] {
    ST_WAIT, ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA,
    ST_SOUT, ST_SRDATA, ST_DONE, ST_SKIP
  } ee_state_e;

  // read or write of the array, address bit 8 masked out
  function automatic logic is_mem_op(input logic [7:0] o);
    return (o & OP_MEM_MASK) == OP_MEM_BASE;
  endfunction

  function automatic ee_state_e after_opcode(input logic [7:0] o, input logic busy);
    if (busy && o != OP_RDSR) return ST_SKIP;
    if (o == OP_RDSR) return ST_SOUT;
    if (o == OP_WREN || o == OP_WRDI) return ST_DONE;
    if (o == OP_WRSR) return ST_SRDATA;
    if (is_mem_op(o)) return ST_ADDR;
    return ST_SKIP;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic paused,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [1:0] cs_q, sck_q, si_q, hd_q;
  logic cs_d, sck_d, hd_d;

  // select sync resets to "selected" so a pin already high is seen as a harmless rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0; sck_q <= '0; si_q <= '0; hd_q <= '1;
      cs_d <= 1'b0; sck_d <= 1'b0; hd_d <= 1'b1; paused <= 1'b0;
    end else begin
      cs_q  <= {cs_q[0], cs_n};
      sck_q <= {sck_q[0], sck};
      si_q  <= {si_q[0], si};
      hd_q  <= {hd_q[0], hold_n};
      cs_d  <= cs_q[1];
      sck_d <= sck_q[1];
      hd_d  <= hd_q[1];
      if (cs_q[1]) paused <= 1'b0;
      else if (hd_q[1] != hd_d && sck_q[1]) paused <= !hd_q[1];
    end
  end

  assign sel      = !cs_q[1];
  assign si_s     = si_q[1];
  assign cs_fall  = !cs_q[1] && cs_d;
  assign cs_rise  = cs_q[1] && !cs_d;
  assign sck_rise = sck_q[1] && !sck_d && sel && !paused;
  assign sck_fall = !sck_q[1] && sck_d && sel && !paused;
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_write_ctrl.sv
module ee_write_ctrl #(
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 5000,
  parameter int AW         = 9,
  localparam int PIW = $clog2(PAGE_BYTES),
  localparam int CW  = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pb_clear,
  input  logic              pb_we,
  input  logic [PIW-1:0]    pb_idx,
  input  logic [7:0]        pb_data,
  input  logic              start_arr,
  input  logic              start_sr,
  input  logic [AW-PIW-1:0] page_in,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [7:0]        mem_wdata
);
  logic [PAGE_BYTES*8-1:0] slot_d;
  logic [PAGE_BYTES-1:0]   slot_v;
  logic [CW-1:0]           cnt;
  logic                    arr_mode;
  logic [AW-PIW-1:0]       page;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] d;
    logic       v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d <= '0; v <= 1'b0;
      end else if (pb_clear) begin
        v <= 1'b0;
      end else if (pb_we && pb_idx == PIW'(g)) begin
        d <= pb_data; v <= 1'b1;
      end
    end
    assign slot_d[g*8 +: 8] = d;
    assign slot_v[g]        = v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; arr_mode <= 1'b0; page <= '0;
    end else if (!busy && (start_arr || start_sr)) begin
      busy <= 1'b1; cnt <= '0; arr_mode <= start_arr; page <= page_in;
    end else if (busy) begin
      if (cnt == CW'(WR_CYCLES - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  // flagged slots go to the array one per clock at the start of the cycle
  assign done      = busy && cnt == CW'(WR_CYCLES - 1);
  assign mem_we    = busy && arr_mode && cnt < CW'(PAGE_BYTES) && slot_v[cnt[PIW-1:0]];
  assign mem_waddr = {page, cnt[PIW-1:0]};
  assign mem_wdata = slot_d[cnt[PIW-1:0]*8 +: 8];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  localparam int AW  = ADDR_W,
  localparam int PIW = $clog2(PAGE_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           paused,
  input  logic           cs_fall,
  input  logic           cs_rise,
  input  logic           sck_rise,
  input  logic           sck_fall,
  input  logic           si_s,
  input  logic           busy,
  input  logic           wr_grant,
  input  logic [7:0]     stat_in,
  input  logic [7:0]     mem_q,
  output logic [AW-1:0]  addr,
  output logic           so,
  output logic           so_oe,
  output logic           pb_clear,
  output logic           pb_we,
  output logic [PIW-1:0] pb_idx,
  output logic [7:0]     pb_data,
  output logic           commit_arr,
  output logic           commit_sr,
  output logic [7:0]     sr_data,
  output logic           wel_set,
  output logic           wel_clr
);
  ee_state_e  st;
  logic [7:0] op, sh, osh, nb, out_byte;
  logic [2:0] bcnt, obit;
  logic       got, live;

  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PIW], a[PIW-1:0] + PIW'(1)};
  endfunction

  assign nb       = {sh[6:0], si_s};
  assign out_byte = (st == ST_RDATA) ? mem_q : (busy ? 8'hFF : stat_in);
  assign so_oe    = sel && !paused && live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_WAIT; op <= '0; sh <= '0; osh <= '0; bcnt <= '0; obit <= '0;
      got <= 1'b0; live <= 1'b0; addr <= '0; so <= 1'b0; sr_data <= '0;
      pb_clear <= 1'b0; pb_we <= 1'b0; pb_idx <= '0; pb_data <= '0;
      commit_arr <= 1'b0; commit_sr <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
    end else begin
      commit_arr <= 1'b0; commit_sr <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
      pb_we <= 1'b0; pb_clear <= 1'b0;
      if (cs_fall) begin
        st <= ST_OPC; bcnt <= '0; got <= 1'b0; live <= 1'b0; obit <= '0;
      end else if (cs_rise) begin
        if (st == ST_WDATA && bcnt == 3'd0 && got && wr_grant) commit_arr <= 1'b1;
        if (st == ST_DONE) begin
          case (op)
            OP_WREN: wel_set <= 1'b1;
            OP_WRDI: wel_clr <= 1'b1;
            OP_WRSR: commit_sr <= wr_grant;
            default: ;
          endcase
        end
        st <= ST_WAIT; live <= 1'b0;
      end else if (sck_fall) begin
        case (st)
          ST_OPC, ST_ADDR, ST_WDATA, ST_SRDATA: begin
            sh   <= nb;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              case (st)
                ST_OPC: begin
                  op <= nb;
                  st <= after_opcode(nb, busy);
                  if (is_mem_op(nb)) addr[AW-1] <= nb[3];
                  if (is_mem_op(nb) && !nb[0]) pb_clear <= 1'b1;
                end
                ST_ADDR: begin
                  addr[7:0] <= nb;
                  st <= op[0] ? ST_RDATA : ST_WDATA;
                end
                ST_WDATA: begin
                  pb_we <= 1'b1; pb_idx <= addr[PIW-1:0]; pb_data <= nb;
                  addr <= page_step(addr); got <= 1'b1;
                end
                default: begin
                  sr_data <= nb; st <= ST_DONE;
                end
              endcase
            end
          end
          ST_DONE: st <= ST_SKIP;
          default: ;
        endcase
      end else if (sck_rise && (st == ST_RDATA || st == ST_SOUT)) begin
        live <= 1'b1;
        obit <= obit + 3'd1;
        if (obit == 3'd0) begin
          so  <= out_byte[7];
          osh <= {out_byte[6:0], 1'b0};
        end else begin
          so  <= osh[7];
          osh <= {osh[6:0], 1'b0};
        end
        if (obit == 3'd7 && st == ST_RDATA) addr <= addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 5000,
  localparam int AW  = ADDR_W,
  localparam int PIW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  input  logic          wr_grant,
  input  logic [7:0]    stat_in,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          sr_load,
  output logic [7:0]    sr_data,
  output logic [AW-1:0] tgt_addr,
  output logic          busy,
  output logic          wr_done
);
  logic sel, paused, cs_fall, cs_rise, sck_rise, sck_fall, si_s;
  logic pb_clear, pb_we, commit_arr, commit_sr, mem_we;
  logic [PIW-1:0] pb_idx;
  logic [7:0] pb_data, mem_q, mem_wdata;
  logic [AW-1:0] mem_waddr;

  spi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .sel(sel), .paused(paused), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  spi_cmd_engine #(.PAGE_BYTES(PAGE_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .sel(sel), .paused(paused), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
    .busy(busy), .wr_grant(wr_grant), .stat_in(stat_in), .mem_q(mem_q),
    .addr(tgt_addr), .so(so), .so_oe(so_oe), .pb_clear(pb_clear), .pb_we(pb_we),
    .pb_idx(pb_idx), .pb_data(pb_data), .commit_arr(commit_arr),
    .commit_sr(commit_sr), .sr_data(sr_data), .wel_set(wel_set), .wel_clr(wel_clr)
  );

  ee_write_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .pb_clear(pb_clear), .pb_we(pb_we), .pb_idx(pb_idx),
    .pb_data(pb_data), .start_arr(commit_arr), .start_sr(commit_sr),
    .page_in(tgt_addr[AW-1:PIW]), .busy(busy), .done(wr_done),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  ee_array #(.DEPTH(1 << AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(tgt_addr), .rdata(mem_q)
  );

  assign sr_load = commit_sr;
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk #(
  parameter int WR_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic so_oe,
  input logic busy,
  input logic wr_done,
  input logic commit_arr,
  input logic commit_sr,
  input logic wr_grant,
  input logic wel_set
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else run <= busy ? run + 1 : 0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == WR_CYCLES); // R8
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !busy); // R8
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_arr || commit_sr) |-> !busy); // R6
  AST_COMMIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_arr || commit_sr) |-> $past(cs_rise)); // R6
  AST_COMMIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_arr || commit_sr) |-> $past(wr_grant)); // R6
  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe); // R10
  AST_WEL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wel_set |=> !wel_set); // R7
endmodule

bind spi_eeprom_slave spi_eeprom_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .so_oe(so_oe), .busy(busy),
  .wr_done(wr_done), .commit_arr(commit_arr), .commit_sr(commit_sr),
  .wr_grant(wr_grant), .wel_set(wel_set)
);

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
  localparam int WRC  = 600;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic wr_grant = 1'b1;
  logic [7:0] stat_in = 8'h0C;
  logic so, so_oe, wel_set, wel_clr, sr_load, busy, wr_done;
  logic [7:0] sr_data;
  logic [8:0] tgt_addr;

  spi_eeprom_slave #(.PAGE_BYTES(4), .WR_CYCLES(WRC)) u_spi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .wr_grant(wr_grant), .stat_in(stat_in),
    .wel_set(wel_set), .wel_clr(wel_clr), .sr_load(sr_load), .sr_data(sr_data),
    .tgt_addr(tgt_addr), .busy(busy), .wr_done(wr_done)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int n_set = 0, n_clr = 0, n_sr = 0, n_done = 0, falls = 0, run = 0, last_len = 0, cs_hi = 0;
  logic [7:0] last_sr = '0;
  logic [7:0] ref_mem [512];
  logic oe_all, oe_any;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model: busy run length, done placement, output release
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
      if (sr_load) begin n_sr++; last_sr = sr_data; end
      if (wr_done) begin
        n_done++;
        chk(busy && run == WRC - 1, "R8 done in last busy clock", run, WRC - 1);
      end
      if (busy) run++;
      else if (run > 0) begin last_len = run; falls++; run = 0; end
      cs_hi = cs_n ? cs_hi + 1 : 0;
      if (cs_hi >= 4 && so_oe) chk(1'b0, "R10 so_oe while deselected", 1, 0);
    end
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit b, output bit got);
    si = b; sck = 1'b1; wait_clk(HALF);
    got = so; oe_all &= so_oe; oe_any |= so_oe;
    sck = 1'b0; wait_clk(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      bit g;
      sbit(tx[i], g);
      rx[i] = g;
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0; wait_clk(HALF); oe_all = 1'b1; oe_any = 1'b0;
  endtask

  task automatic sel_off();
    cs_n = 1'b1; wait_clk(3 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel_on(); xbyte(op, r); sel_off();
  endtask

  task automatic wait_write(input bit expect_w, input int f0, input string req);
    int t = 0;
    while (falls == f0 && t < WRC + 200) begin wait_clk(1); t++; end
    if (expect_w) begin
      chk(falls == f0 + 1, req, falls - f0, 1);
      chk(last_len == WRC, "R8 busy length", last_len, WRC);
    end else chk(falls == f0, req, falls - f0, 0);
  endtask

  task automatic write_mem(input logic [8:0] a, input int n, input logic [7:0] v0,
                           input bit expect_w, input string req);
    logic [7:0] r;
    int f0;
    int idx;
    cmd1(8'h06);
    f0 = falls;
    sel_on();
    xbyte({4'b0000, a[8], 3'b010}, r);
    xbyte(a[7:0], r);
    idx = int'(a[1:0]);
    for (int k = 0; k < n; k++) begin
      xbyte(v0 + 8'(k), r);
      if (expect_w) ref_mem[{a[8:2], 2'(idx)}] = v0 + 8'(k);
      idx = (idx + 1) % 4;
    end
    sel_off();
    wait_write(expect_w, f0, req);
  endtask

  task automatic read_mem(input logic [8:0] a, input int n, input string req);
    logic [7:0] r;
    sel_on();
    xbyte({4'b0000, a[8], 3'b011}, r);
    xbyte(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r);
      chk(r == ref_mem[9'(int'(a) + k)], req, r, ref_mem[9'(int'(a) + k)]);
    end
    chk(oe_any, "R10 so_oe during read", oe_any, 1);
    sel_off();
  endtask

  task automatic rdsr(output logic [7:0] r);
    logic [7:0] d;
    sel_on(); xbyte(8'h05, d); xbyte(8'h00, r); sel_off();
  endtask

  initial begin
    logic [7:0] r, acc;
    int s0, f0;
    for (int i = 0; i < 512; i++) ref_mem[i] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(1);
    chk(so_oe == 1'b0, "R1 reset so_oe", so_oe, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);

    // cs_n low since reset: no falling edge seen yet, so command is dropped
    xbyte(8'h06, r);
    cs_n = 1'b1; wait_clk(3 * HALF);
    chk(n_set == 0, "R1 command before first select edge", n_set, 0);

    s0 = n_set; cmd1(8'h06);
    chk(n_set == s0 + 1, "R7 WREN sets latch", n_set - s0, 1);
    s0 = n_set;
    begin bit g; sel_on(); xbyte(8'h06, r); sbit(1'b0, g); sel_off(); end
    chk(n_set == s0, "R7 WREN with extra clock ignored", n_set - s0, 0);
    s0 = n_clr; cmd1(8'h04);
    chk(n_clr == s0 + 1, "R2 WRDI clears latch", n_clr - s0, 1);
    s0 = n_set + n_clr; cmd1(8'h07);
    chk(n_set + n_clr == s0, "R2 unknown opcode ignored", n_set + n_clr - s0, 0);

    write_mem(9'h1FC, 4, 8'hA0, 1'b1, "R5 page write top");
    write_mem(9'h000, 4, 8'hB0, 1'b1, "R5 page write bottom");
    write_mem(9'h0FC, 4, 8'hC0, 1'b1, "R2 page write A8 low");
    read_mem(9'h1FE, 4, "R3 read wraps 1FF to 000");
    read_mem(9'h0FC, 4, "R2 address bit 8 from opcode");
    read_mem(9'h1FC, 2, "R2 upper half kept");

    write_mem(9'h011, 6, 8'hD0, 1'b1, "R5 six bytes wrap in page");
    read_mem(9'h010, 4, "R5 in-page overwrite");
    write_mem(9'h020, 4, 8'h40, 1'b1, "R5 full page");
    write_mem(9'h021, 2, 8'h70, 1'b1, "R5 partial page");
    read_mem(9'h020, 4, "R5 unflagged slots kept");

    // abandoned: select rises mid-byte
    cmd1(8'h06);
    f0 = falls;
    sel_on(); xbyte(8'h02, r); xbyte(8'h10, r);
    for (int i = 0; i < 4; i++) begin bit g; sbit(1'b1, g); end
    sel_off();
    wait_write(1'b0, f0, "R6 mid-byte rise abandons");
    read_mem(9'h010, 4, "R6 array unchanged after abandon");

    wr_grant = 1'b0;
    write_mem(9'h010, 1, 8'h99, 1'b0, "R6 no grant no write");
    wr_grant = 1'b1;
    read_mem(9'h010, 1, "R6 array unchanged without grant");

    // status and lockout during a write cycle
    cmd1(8'h06);
    f0 = falls; s0 = n_done;
    sel_on(); xbyte(8'h02, r); xbyte(8'h30, r); xbyte(8'h5A, r); sel_off();
    ref_mem[9'h030] = 8'h5A;
    rdsr(r);
    chk(r == 8'hFF, "R4 status during write", r, 8'hFF);
    sel_on(); xbyte(8'h03, r); xbyte(8'h30, r); xbyte(8'h00, r);
    chk(oe_any == 1'b0, "R8 read refused while busy", oe_any, 0);
    sel_off();
    wait_write(1'b1, f0, "R8 write cycle completes");
    chk(n_done == s0 + 1, "R8 one done pulse", n_done - s0, 1);
    rdsr(r);
    chk(r == stat_in, "R4 status when idle", r, stat_in);
    read_mem(9'h030, 1, "R8 data written after cycle");

    // pause in the middle of a read byte
    sel_on(); xbyte(8'h03, r); xbyte(8'h20, r);
    for (int i = 7; i >= 0; i--) begin
      bit g, g2;
      if (i == 4) begin
        si = 1'b0; sck = 1'b1; wait_clk(HALF);
        g = so;
        hold_n = 1'b0; wait_clk(HALF);
        chk(so_oe == 1'b0, "R9 SO released while paused", so_oe, 0);
        sck = 1'b0; si = 1'b1; wait_clk(HALF);
        sck = 1'b1; wait_clk(HALF);
        hold_n = 1'b1; wait_clk(HALF);
        g2 = so;
        chk(so_oe == 1'b1, "R9 SO driven after resume", so_oe, 1);
        chk(g2 == g, "R9 bit kept across pause", g2, g);
        sck = 1'b0; wait_clk(HALF);
        acc[i] = g2;
      end else begin
        sbit(1'b0, g);
        acc[i] = g;
      end
    end
    chk(acc == ref_mem[9'h020], "R9 byte intact across pause", acc, ref_mem[9'h020]);
    xbyte(8'h00, r);
    chk(r == ref_mem[9'h021], "R9 stream continues", r, ref_mem[9'h021]);
    sel_off();

    // status write
    f0 = falls; s0 = n_sr;
    sel_on(); xbyte(8'h01, r); xbyte(8'h08, r); sel_off();
    chk(n_sr == s0 + 1, "R11 status write pulse", n_sr - s0, 1);
    chk(last_sr == 8'h08, "R11 status data", last_sr, 8'h08);
    wait_write(1'b1, f0, "R11 status write cycle");
    f0 = falls; s0 = n_sr;
    begin bit g; sel_on(); xbyte(8'h01, r); xbyte(8'h0C, r); sbit(1'b0, g); sel_off(); end
    chk(n_sr == s0, "R6 status write extra bit abandoned", n_sr - s0, 0);
    wait_write(1'b0, f0, "R6 no cycle after abandoned status write");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule